// File: doc/BRIEF.md
# Bus Hold Request Arbiter

This block decides when a processor yields its shared system bus to an outside master such as a DMA engine. It samples an active-high hold request on each rising clock edge. It looks at the bus-cycle state reported by the processor's cycle sequencer and at a lock condition. From these it produces three outputs: a hold acknowledge, a float command that puts every bus driver in high impedance, and a stall that stops the sequencer from starting a new cycle.

A grant is only issued at a cycle boundary, so a bus cycle that has started always runs to its last state. While the lock condition is active, no grant is issued. Once granted, the bus stays with the outside master until it withdraws its request. The acknowledge then drops, and the float command is held for one more clock. This spacing keeps the two masters from driving the bus at the same moment.

Top module: `hold_arbiter`

## Requirements
- R1: A synchronous active-high `rst` clears `hold_ack` and `bus_float` on the next edge. This holds even while `hold_req` is high.
- R2: `bus_state` uses the code 0 for idle and 5 for the last state of a cycle. If a rising edge samples `hold_req` high and `lock` low while `bus_state` is one of these two codes, then `hold_ack` and `bus_float` are high after that edge.
- R3: Codes 1, 2, 3 and 4 on `bus_state` mean a cycle is in progress: first, second and third state, and wait state. An edge that samples one of these codes never raises `hold_ack`, so a running cycle is finished first.
- R4: An edge that samples `lock` high never raises `hold_ack`. A request that is still pending gets its grant on the first boundary edge after `lock` goes low.
- R5: Whenever `hold_ack` is high, `bus_float` is high.
- R6: While `hold_ack` is high, an edge that samples `hold_req` high keeps it high, whatever `lock` and `bus_state` show.
- R7: An edge that samples `hold_req` low while `hold_ack` is high lowers `hold_ack`. `bus_float` falls one edge later.
- R8: `seq_stall` is high whenever `bus_float` is high, or when `hold_req` is high and `lock` is low. It is low otherwise.
- R9: If a request is withdrawn before it is granted, no acknowledge is ever given for it.
- R10: The unused `bus_state` codes 6 and 7 never allow a grant.
- R11: A new request that is sampled at a boundary during the one-clock float tail re-grants at once. In that case `bus_float` stays high without a gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| hold_req | input | 1 | Request for the bus from the outside master |
| lock | input | 1 | Lock condition; blocks new grants |
| bus_state | input | 3 | Sequencer state: 0 idle, 1 first, 2 second, 3 third, 4 wait, 5 last |
| hold_ack | output | 1 | Hold acknowledge to the outside master |
| bus_float | output | 1 | Tristate command for address, data and control drivers |
| seq_stall | output | 1 | Stops the sequencer from starting a new cycle |

## Verification
A wrong arbiter state shows up within one clock. An acknowledge raised in mid-cycle or under lock appears on `hold_ack` at the first edge that sampled the forbidden condition. A missing float tail shows as `bus_float` falling in the same edge as `hold_ack`. A grant that was never released shows as `seq_stall` staying high after the request is gone. The stimulus walks the request through every sequencer code, with and without lock. It also covers withdrawal and re-request during the float tail, where these faults would be exposed.

// File: rtl/hold_arb_pkg.sv
package hold_arb_pkg;
    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        BS_IDLE = 3'd0,
        BS_T1   = 3'd1,
        BS_T2   = 3'd2,
        BS_T3   = 3'd3,
        BS_TW   = 3'd4,
        BS_T4   = 3'd5
    } bus_state_e;

    typedef enum logic [1:0] {
        ARB_OWN   = 2'd0,
        ARB_GRANT = 2'd1,
        ARB_TAIL  = 2'd2
    } arb_state_e;

    typedef struct packed {
        arb_state_e st;
        logic       ack;
        logic       flt;
    } arb_regs_t;
endpackage

// File: rtl/hold_cycle_decode.sv
module hold_cycle_decode
    import hold_arb_pkg::*;
#(
    parameter int W = STATE_W
) (
    input  logic [W-1:0] bus_state,
    output logic         at_boundary
);
    localparam logic [W-1:0] CODE_IDLE = W'(BS_IDLE);
    localparam logic [W-1:0] CODE_LAST = W'(BS_T4);

    always_comb begin
        at_boundary = (bus_state == CODE_IDLE) || (bus_state == CODE_LAST);
    end
endmodule

// File: rtl/hold_grant_fsm.sv
module hold_grant_fsm
    import hold_arb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hold_req,
    input  logic lock,
    input  logic at_boundary,
    output logic ack_q_o,
    output logic flt_q_o
);
    arb_regs_t regs_d, regs_q;
    logic      may_grant;

    always_comb begin
        may_grant = hold_req && !lock && at_boundary;
        regs_d    = regs_q;
        case (regs_q.st)
            ARB_OWN: begin
                if (may_grant) regs_d.st = ARB_GRANT;
            end
            ARB_GRANT: begin
                if (!hold_req) regs_d.st = ARB_TAIL;
            end
            ARB_TAIL: begin
                regs_d.st = may_grant ? ARB_GRANT : ARB_OWN;
            end
            default: regs_d.st = ARB_OWN;
        endcase
        regs_d.ack = (regs_d.st == ARB_GRANT);
        regs_d.flt = (regs_d.st != ARB_OWN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '{st: ARB_OWN, ack: 1'b0, flt: 1'b0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign ack_q_o = regs_q.ack;
    assign flt_q_o = regs_q.flt;
endmodule

// File: rtl/hold_stall_gen.sv
module hold_stall_gen (
    input  logic hold_req,
    input  logic lock,
    input  logic flt_q,
    output logic seq_stall
);
    always_comb begin
        seq_stall = flt_q || (hold_req && !lock);
    end
endmodule

// File: rtl/hold_arbiter.sv
module hold_arbiter
    import hold_arb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               hold_req,
    input  logic               lock,
    input  logic [STATE_W-1:0] bus_state,
    output logic               hold_ack,
    output logic               bus_float,
    output logic               seq_stall
);
    logic at_boundary;
    logic ack_q;
    logic flt_q;

    hold_cycle_decode #(.W(STATE_W)) u_decode (
        .bus_state  (bus_state),
        .at_boundary(at_boundary)
    );

    hold_grant_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .hold_req   (hold_req),
        .lock       (lock),
        .at_boundary(at_boundary),
        .ack_q_o    (ack_q),
        .flt_q_o    (flt_q)
    );

    hold_stall_gen u_stall (
        .hold_req (hold_req),
        .lock     (lock),
        .flt_q    (flt_q),
        .seq_stall(seq_stall)
    );

    assign hold_ack  = ack_q;
    assign bus_float = flt_q;
endmodule

// File: rtl/hold_arbiter_chk.sv
module hold_arbiter_chk (
    input logic       clk,
    input logic       rst,
    input logic       hold_req,
    input logic       lock,
    input logic [2:0] bus_state,
    input logic       hold_ack,
    input logic       bus_float,
    input logic       seq_stall
);
    logic edge_ok;
    assign edge_ok = (bus_state == 3'd0) || (bus_state == 3'd5);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!hold_ack && !bus_float));

    // R2
    grant_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_req && !lock && edge_ok) |=> hold_ack);

    // R3
    no_grant_mid_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold_ack && !edge_ok) |=> !hold_ack);

    // R4
    no_grant_locked_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold_ack && lock) |=> !hold_ack);

    // R5
    ack_implies_float_chk: assert property (@(posedge clk) disable iff (rst)
        hold_ack |-> bus_float);

    // R6
    grant_held_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_ack && hold_req) |=> hold_ack);

    // R7
    release_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_ack && !hold_req) |=> (!hold_ack && bus_float));

    // R7
    float_tail_end_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_float && !hold_ack) |=> (!bus_float || hold_ack));

    // R8
    stall_on_float_chk: assert property (@(posedge clk) disable iff (rst)
        bus_float |-> seq_stall);

    // R9
    no_grant_unrequested_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold_ack && !hold_req) |=> !hold_ack);
endmodule

bind hold_arbiter hold_arbiter_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .hold_req (hold_req),
    .lock     (lock),
    .bus_state(bus_state),
    .hold_ack (hold_ack),
    .bus_float(bus_float),
    .seq_stall(seq_stall)
);

// File: tb/hold_arbiter_tb_top.sv
module hold_arbiter_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       hold_req;
    logic       lock;
    logic [2:0] bus_state;
    logic       hold_ack;
    logic       bus_float;
    logic       seq_stall;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    hold_arbiter dut_i (
        .clk      (clk),
        .rst      (rst),
        .hold_req (hold_req),
        .lock     (lock),
        .bus_state(bus_state),
        .hold_ack (hold_ack),
        .bus_float(bus_float),
        .seq_stall(seq_stall)
    );

    // {hold, lock, state[2:0], stall before edge, ack after edge, float after edge}
    localparam int NV = 23;
    localparam logic [7:0] VEC [0:NV-1] = '{
        8'b0_0_000_0_0_0, // R9 quiet
        8'b1_0_010_1_0_0, // R3 T2
        8'b1_0_011_1_0_0, // R3 T3
        8'b1_0_100_1_0_0, // R3 wait
        8'b1_0_101_1_1_1, // R2 last state
        8'b1_0_000_1_1_1, // R6
        8'b1_1_011_1_1_1, // R6 lock ignored
        8'b0_0_000_1_0_1, // R7 release
        8'b0_0_000_1_0_0, // R7 tail end
        8'b0_0_000_0_0_0, // R8
        8'b1_1_000_0_0_0, // R4 locked idle
        8'b1_1_101_0_0_0, // R4 locked last
        8'b1_0_001_1_0_0, // R4 unlocked but T1
        8'b1_0_110_1_0_0, // R10 code 6
        8'b1_0_111_1_0_0, // R10 code 7
        8'b1_0_000_1_1_1, // R4 grant after lock
        8'b0_0_000_1_0_1, // R7
        8'b1_0_000_1_1_1, // R11 regrant in tail
        8'b0_0_000_1_0_1, // R11
        8'b0_0_000_1_0_0, // R7
        8'b1_0_011_1_0_0, // R9 pending
        8'b0_0_101_0_0_0, // R9 withdrawn
        8'b0_0_000_0_0_0  // R9
    };
    localparam string TAG [0:NV-1] = '{
        "R9", "R3", "R3", "R3", "R2", "R6", "R6", "R7", "R7", "R8",
        "R4", "R4", "R4", "R10", "R10", "R4", "R7", "R11", "R11", "R7",
        "R9", "R9", "R9"
    };

    task automatic check(input string req, input string what,
                         input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    initial begin
        rst = 1'b1; hold_req = 1'b0; lock = 1'b0; bus_state = 3'd0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "ack after reset", hold_ack, 1'b0);
        check("R1", "float after reset", bus_float, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            hold_req  = VEC[i][7];
            lock      = VEC[i][6];
            bus_state = VEC[i][5:3];
            #1;
            check(TAG[i], "stall", seq_stall, VEC[i][2]);
            @(negedge clk);
            check(TAG[i], "ack", hold_ack, VEC[i][1]);
            check(TAG[i], "float", bus_float, VEC[i][0]);
        end
        // R1: reset while granted and request held
        hold_req = 1'b1; lock = 1'b0; bus_state = 3'd0;
        @(negedge clk);
        check("R2", "ack before reset", hold_ack, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        check("R1", "ack under reset", hold_ack, 1'b0);
        check("R1", "float under reset", bus_float, 1'b0);
        // R8: locked request gives no stall
        lock = 1'b1; rst = 1'b0;
        #1;
        check("R8", "stall locked", seq_stall, 1'b0);
        @(negedge clk);
        check("R4", "ack locked", hold_ack, 1'b0);
        done = 1'b1;
    end

    initial begin
        for (int n = 0; n < 2000; n++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule